// File: doc/BRIEF.md
# Marked Lane Bit-Interleave Codec

This block joins a set of parallel lanes into one serial stream and splits a serial stream back into lanes. On the transmit side, every group period it takes one bit from each lane. It sends those bits one per clock, lowest lane first. One chosen lane is inverted before it goes out. That lane acts as a marker, so the far end can tell which received bit position belongs to which lane. On the receive side, the block collects one group of serial bits. It hands the group to the parallel outputs through a lane rotation, and it undoes the marker inversion on the chosen output lane.

The lane rotation is an offset register. An external frame-search circuit advances it with a single-cycle roll pulse. It keeps rolling until its pattern shows up on the expected lane. A new offset takes hold only on a group boundary, so no output group ever mixes two assignments. Two loopback selects are provided for system testing. One sends the serial input straight back out. The other sends the parallel inputs straight to the parallel outputs.

The block runs on a single clock, and one serial bit moves per clock. Group boundaries repeat every `LANES` clocks, counted from the release of reset.

Top module: `ilv_codec`

## Requirements
- R1: While reset is held, and right after it is released, `ser_out`, `par_out` and `rot_offset` are all zero.
- R2: Group boundaries fall on clock edges 3, 7, 11 and so on, counted from the first edge after reset release, for the default `LANES` = 4. `par_in` is sampled on each boundary edge. Its lane 0 bit drives `ser_out` after that edge, and lanes 1 to 3 follow on the next three edges.
- R3: The marked lane is inverted on the serial output, and all other lanes are sent true. The marked lane is lane index 3 by default (`MARK_LANE`).
- R4: Say the demux samples bit k of a group (k = 0..3) on the k-th edge of that group, and the group ends at the boundary edge. On that edge `par_out[j]` takes bit number (j + offset) mod 4 of the group. It holds that value until the next boundary edge.
- R5: The marked output lane (index 3) is inverted back after the rotation, so a lane that passes through the codec returns true.
- R6: Each clock with `roll` high adds one to the pending offset, modulo 4. Several rolls add up and wrap from 3 to 0. With no roll since the last boundary, the offset stays unchanged.
- R7: `rot_offset` changes only on a boundary edge. A roll sampled on that same edge is included. The group that finishes on that edge still uses the previous offset.
- R8: When `ser_out` reaches `ser_in` through a delay of D register stages (D = 1..4), setting the offset to D mod 4 makes `par_out` equal to a steady `par_in`.
- R9: While `line_loop` is high, `ser_out` follows `ser_in` with no register in between.
- R10: While `par_loop` is high, `par_out` follows `par_in` with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_loop | input | 1 | Drive `ser_out` from `ser_in` |
| par_loop | input | 1 | Drive `par_out` from `par_in` |
| par_in | input | LANES | Lane bits to serialise, sampled on boundary edges |
| ser_out | output | 1 | Interleaved serial output |
| ser_in | input | 1 | Interleaved serial input |
| roll | input | 1 | Single-cycle request to advance the lane offset |
| par_out | output | LANES | De-interleaved lane bits |
| rot_offset | output | $clog2(LANES) | Lane offset currently applied |

## Verification
The bench uses the default build: four lanes, with the marker on lane index 3. In this build, a link delay of one to four stages covers every rotation offset, including the wrap back to zero. The bench also runs with a deliberately wrong offset. That makes the marker inversion appear on the outputs as a value the bench can predict, so it checks the inversion on both sides, not just that the two inversions cancel.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   // Lane count must be a power of two so the offset wraps by plain overflow.
   function automatic bit lanes_ok(int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

   function automatic bit mark_ok(int n, int m);
      return (m >= 0) && (m < n);
   endfunction

endpackage

// File: rtl/ilv_phase.sv
module ilv_phase #(
   parameter int LANES = 4,
   localparam int RW = $clog2(LANES)
) (
   input  logic clk,
   input  logic rst_n,
   output logic bnd
);

   logic [RW-1:0] ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + 1'b1;
   end

   assign bnd = (ph_q == RW'(LANES - 1));

endmodule

// File: rtl/ilv_mux.sv
module ilv_mux #(
   parameter int LANES     = 4,
   parameter int MARK_LANE = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd,
   input  logic [LANES-1:0] par_in,
   output logic             ser
);

   logic [LANES-1:0] coded;
   logic [LANES-1:0] sh_q;

   for (genvar i = 0; i < LANES; i++) begin : g_code
      if (i == MARK_LANE) begin : g_inv
         assign coded[i] = ~par_in[i];
      end else begin : g_true
         assign coded[i] = par_in[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sh_q <= '0;
      else if (bnd) sh_q <= coded;
      else          sh_q <= {1'b0, sh_q[LANES-1:1]};
   end

   assign ser = sh_q[0];

endmodule

// File: rtl/ilv_rot.sv
module ilv_rot #(
   parameter int LANES = 4,
   localparam int RW = $clog2(LANES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bnd,
   input  logic          roll,
   output logic [RW-1:0] rot
);

   logic [RW-1:0] pend_q;
   logic [RW-1:0] pend_nxt;
   logic [RW-1:0] cur_q;

   assign pend_nxt = pend_q + RW'(roll);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         cur_q  <= '0;
      end else begin
         pend_q <= pend_nxt;
         if (bnd) cur_q <= pend_nxt;
      end
   end

   assign rot = cur_q;

endmodule

// File: rtl/ilv_demux.sv
module ilv_demux #(
   parameter int LANES     = 4,
   parameter int MARK_LANE = 3,
   localparam int RW = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bnd,
   input  logic             ser,
   input  logic [RW-1:0]    rot,
   output logic [LANES-1:0] par
);

   logic [LANES-1:0] sh_q;
   logic [LANES-1:0] grp;
   logic [LANES-1:0] lane_d;
   logic [LANES-1:0] par_q;

   // Newest bit enters at the top; after LANES shifts bit k sits at index k.
   assign grp = {ser, sh_q[LANES-1:1]};

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [RW-1:0] src;
      assign src = RW'(j) + rot;
      if (j == MARK_LANE) begin : g_inv
         assign lane_d[j] = ~grp[src];
      end else begin : g_true
         assign lane_d[j] = grp[src];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         par_q <= '0;
      end else begin
         sh_q <= grp;
         if (bnd) par_q <= lane_d;
      end
   end

   assign par = par_q;

endmodule

// File: rtl/ilv_codec.sv
module ilv_codec #(
   parameter int LANES     = 4,
   parameter int MARK_LANE = 3,
   localparam int RW = $clog2(LANES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_loop,
   input  logic             par_loop,
   input  logic [LANES-1:0] par_in,
   output logic             ser_out,
   input  logic             ser_in,
   input  logic             roll,
   output logic [LANES-1:0] par_out,
   output logic [RW-1:0]    rot_offset
);

   if (!ilv_pkg::lanes_ok(LANES)) begin : g_bad_lanes
      $error("ilv_codec: LANES must be a power of two of at least 2");
   end
   if (!ilv_pkg::mark_ok(LANES, MARK_LANE)) begin : g_bad_mark
      $error("ilv_codec: MARK_LANE must index an existing lane");
   end

   logic             bnd;
   logic             tx_ser;
   logic [LANES-1:0] rx_par;

   ilv_phase #(.LANES(LANES)) u_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .bnd   (bnd)
   );

   ilv_mux #(.LANES(LANES), .MARK_LANE(MARK_LANE)) u_mux (
      .clk    (clk),
      .rst_n  (rst_n),
      .bnd    (bnd),
      .par_in (par_in),
      .ser    (tx_ser)
   );

   ilv_rot #(.LANES(LANES)) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .bnd   (bnd),
      .roll  (roll),
      .rot   (rot_offset)
   );

   ilv_demux #(.LANES(LANES), .MARK_LANE(MARK_LANE)) u_demux (
      .clk   (clk),
      .rst_n (rst_n),
      .bnd   (bnd),
      .ser   (ser_in),
      .rot   (rot_offset),
      .par   (rx_par)
   );

   assign ser_out = line_loop ? ser_in : tx_ser;
   assign par_out = par_loop  ? par_in : rx_par;

endmodule

// File: rtl/ilv_codec_chk.sv
module ilv_codec_chk #(
   parameter int LANES     = 4,
   parameter int MARK_LANE = 3,
   localparam int RW = $clog2(LANES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             line_loop,
   input logic             par_loop,
   input logic [LANES-1:0] par_in,
   input logic             ser_out,
   input logic             roll,
   input logic [LANES-1:0] par_out,
   input logic [RW-1:0]    rot_offset
);

   logic [RW-1:0]    ph;
   logic             bnd;
   logic [LANES-1:0] cap;
   logic             cap_ok;
   logic             seen_roll;

   assign bnd = (ph == RW'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph        <= '0;
         cap       <= '0;
         cap_ok    <= 1'b0;
         seen_roll <= 1'b0;
      end else begin
         ph <= ph + 1'b1;
         if (bnd) begin
            cap       <= par_in;
            cap_ok    <= 1'b1;
            seen_roll <= 1'b0;
         end else if (roll) begin
            seen_roll <= 1'b1;
         end
      end
   end

   // R2 R3
   tx_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_ok && !line_loop) |-> (ser_out == (cap[ph] ^ (ph == RW'(MARK_LANE)))));

   // R7
   rot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bnd |=> $stable(rot_offset));

   // R6
   rot_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bnd && !seen_roll && !roll) |=> $stable(rot_offset));

   // R4
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bnd && !par_loop) |=> (par_loop || $stable(par_out)));

endmodule

bind ilv_codec ilv_codec_chk #(.LANES(LANES), .MARK_LANE(MARK_LANE)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .line_loop  (line_loop),
   .par_loop   (par_loop),
   .par_in     (par_in),
   .ser_out    (ser_out),
   .roll       (roll),
   .par_out    (par_out),
   .rot_offset (rot_offset)
);

// File: tb/test_ilv_codec.sv
module test_ilv_codec;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_loop = 1'b0;
   logic       par_loop = 1'b0;
   logic [3:0] par_in = '0;
   logic       ser_out;
   logic       ser_in;
   logic       roll = 1'b0;
   logic [3:0] par_out;
   logic [1:0] rot_offset;

   logic       use_chain = 1'b0;
   logic [1:0] dsel = '0;
   logic       ser_drv = 1'b0;
   logic [3:0] dly = '0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   ilv_codec i_ilv_codec (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_loop  (line_loop),
      .par_loop   (par_loop),
      .par_in     (par_in),
      .ser_out    (ser_out),
      .ser_in     (ser_in),
      .roll       (roll),
      .par_out    (par_out),
      .rot_offset (rot_offset)
   );

   // Link model: dsel + 1 register stages from ser_out to ser_in.
   always_ff @(posedge clk) dly <= {dly[2:0], ser_out};
   assign ser_in = use_chain ? dly[dsel] : ser_drv;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic adv(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [3:0] exp_dmx(input logic [3:0] b, input int rot);
      logic [3:0] e;
      for (int j = 0; j < 4; j++) e[j] = b[(j + rot) % 4] ^ (j == 3);
      return e;
   endfunction

   function automatic logic [3:0] exp_link(input logic [3:0] p, input int rot, input int d);
      logic [3:0] e;
      for (int j = 0; j < 4; j++) begin
         int l;
         l = (j + rot - d + 8) % 4;
         e[j] = p[l] ^ (l == 3) ^ (j == 3);
      end
      return e;
   endfunction

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      roll = 1'b0; ser_drv = 1'b0; line_loop = 1'b0; par_loop = 1'b0;
      use_chain = 1'b0; par_in = '0;
      adv(3);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      do_reset();
      check(ser_out == 1'b0, "R1 ser_out after reset", 32'(ser_out), 0);
      check(par_out == 4'h0, "R1 par_out after reset", 32'(par_out), 0);
      check(rot_offset == 2'd0, "R1 rot_offset after reset", 32'(rot_offset), 0);
   endtask

   task automatic tx_grp(input logic [3:0] p);
      par_in = p;
      for (int k = 0; k < 4; k++) begin
         adv(1);
         check(ser_out == (p[k] ^ (k == 3)), $sformatf("R2 R3 serial bit %0d of %h", k, p),
               32'(ser_out), 32'(p[k] ^ (k == 3)));
      end
   endtask

   task automatic t_mux;
      do_reset();
      adv(3);
      tx_grp(4'b0000);
      tx_grp(4'b1010);
      tx_grp(4'b0111);
      tx_grp(4'b1111);
   endtask

   // One received group; rl[k] raises roll during bit k.
   task automatic rx_grp(input logic [3:0] b, input logic [3:0] rl, inout int cur, inout int pend);
      logic [3:0] e;
      for (int k = 0; k < 4; k++) begin
         ser_drv = b[k];
         roll = rl[k];
         if (rl[k]) pend = (pend + 1) % 4;
         adv(1);
         if (k == 1)
            check(rot_offset == 2'(cur), "R7 offset steady inside group", 32'(rot_offset), 32'(cur));
      end
      roll = 1'b0;
      e = exp_dmx(b, cur);
      check(par_out == e, $sformatf("R4 R5 group %h at offset %0d", b, cur), 32'(par_out), 32'(e));
      cur = pend;
      check(rot_offset == 2'(cur), "R6 offset after boundary", 32'(rot_offset), 32'(cur));
   endtask

   task automatic t_demux;
      int cur = 0;
      int pend = 0;
      do_reset();
      rx_grp(4'b0110, 4'b0000, cur, pend);
      rx_grp(4'b1001, 4'b0010, cur, pend);
      rx_grp(4'b0011, 4'b0000, cur, pend);
      rx_grp(4'b1100, 4'b1011, cur, pend);
      rx_grp(4'b0101, 4'b0000, cur, pend);
      rx_grp(4'b1110, 4'b1000, cur, pend);
      rx_grp(4'b0100, 4'b0101, cur, pend);
      rx_grp(4'b1011, 4'b0000, cur, pend);
   endtask

   task automatic t_link(input int d, input int r, input string req);
      logic [3:0] pats [3] = '{4'b1010, 4'b0001, 4'b1101};
      do_reset();
      use_chain = 1'b1;
      dsel = 2'(d - 1);
      for (int i = 0; i < r; i++) begin
         roll = 1'b1;
         adv(1);
      end
      roll = 1'b0;
      foreach (pats[i]) begin
         logic [3:0] e;
         par_in = pats[i];
         adv(20);
         e = exp_link(pats[i], r, d);
         check(par_out == e, $sformatf("%s delay %0d offset %0d pattern %h", req, d, r, pats[i]),
               32'(par_out), 32'(e));
      end
      check(rot_offset == 2'(r), $sformatf("%s offset held", req), 32'(rot_offset), 32'(r));
   endtask

   task automatic t_loops;
      do_reset();
      adv(2);
      line_loop = 1'b1;
      ser_drv = 1'b1;
      #1 check(ser_out == 1'b1, "R9 line loop high", 32'(ser_out), 1);
      ser_drv = 1'b0;
      #1 check(ser_out == 1'b0, "R9 line loop low", 32'(ser_out), 0);
      line_loop = 1'b0;
      par_loop = 1'b1;
      par_in = 4'b1011;
      #1 check(par_out == 4'b1011, "R10 parallel loop", 32'(par_out), 32'hb);
      par_in = 4'b0100;
      #1 check(par_out == 4'b0100, "R10 parallel loop", 32'(par_out), 32'h4);
      par_loop = 1'b0;
   endtask

   initial begin
      #(200000 * 4);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_mux();
      t_demux();
      t_link(1, 1, "R8");
      t_link(2, 2, "R8");
      t_link(3, 3, "R8");
      t_link(4, 0, "R8");
      t_link(2, 0, "R3 R5 misaligned");
      t_link(3, 1, "R3 R5 misaligned");
      t_loops();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule